// File: doc/BRIEF.md
# Packet-Locked Shared Link Arbiter

This block lets several channel endpoints take turns on one inter-chip link. Each sender offers tokens one at a time with valid/ready handshaking. A token is 9 bits: bit 8 is a control flag and bits 7:0 are the payload. The first token a sender gets accepted claims the link for that sender. The claim lasts until the same sender gets an END control token accepted. END has the control flag set and payload 0x01. After that the link is free, and the next packet may come from any channel and go to any destination.

Accepted tokens are tagged with their destination and go into a small first-in first-out token buffer. Only the buffer head is presented, and only to its own destination. If that destination is not ready, the head waits and no token is lost. Every later token queues behind it, so the link stays effectively occupied. Once the buffer is full, the current owner is stalled.

Each destination has a busy flag. It is set when the first payload token of a packet is handed to that destination and cleared when the END token of that packet is consumed there. A packet that holds only END can serve as a zero-payload readiness handshake. It never claims the link and never marks its destination busy.

Top module: `pkt_link_arb`

## Requirements
- R1: After reset the link is idle (`link_busy`=0), every `src_ready` is 0 while no sender is valid, and all `dst_valid` and `dst_busy` bits are 0.
- R2: While the link is owned, only the owner may see `src_ready`=1. Other valid senders are held off, and `link_owner` reports the owner's index.
- R3: Only an accepted END token (flag=1, payload 0x01) releases the link. A control token with any other payload, for example flag=1 with payload 0x05, keeps the link owned.
- R4: When the link is idle and several senders are valid, the grant goes to the first valid index after the previous winner, counting upward and wrapping. After reset the previous winner is taken to be the highest index.
- R5: Tokens reach the destination side in exactly the order they were accepted. Each carries the destination it was sent with, and none are lost or duplicated.
- R6: When the buffer holds DEPTH tokens, every `src_ready` is 0. Acceptance resumes once a token has been consumed.
- R7: At most one `dst_valid` bit is high at a time, the one for the head token's destination. It stays high with unchanged data while that destination is not ready.
- R8: `dst_busy[d]` becomes 1 once a non-END token is consumed at destination d. It returns to 0 once an END token is consumed there.
- R9: A packet that consists only of END is accepted without leaving the link owned, is delivered normally, and leaves the destination's busy flag at 0.
- R10: A head token whose destination is not ready blocks delivery of every later token, including tokens for other destinations that are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_valid | input | NSRC | Per-sender token offered |
| src_data | input | NSRC*9 | Per-sender token, sender i in bits [9i+8:9i] |
| src_dest | input | NSRC*log2(NDST) | Per-sender destination index |
| src_ready | output | NSRC | Per-sender token accepted this cycle |
| dst_valid | output | NDST | Head token presented to this destination |
| dst_data | output | 9 | Head token |
| dst_ready | input | NDST | Destination takes the head token |
| dst_busy | output | NDST | Destination is inside a packet |
| link_busy | output | 1 | Link owned by a sender |
| link_owner | output | log2(NSRC) | Index of the last granted sender |

## Verification
Two things can fall in the same cycle. A token can leave a full buffer while the stalled owner waits to push. The last END of one packet can be delivered while another sender contends for the freed link. The first is provoked by filling the buffer, holding the owner's next token offered, and then opening every destination. The check is that the stalled tokens arrive right after the queued ones, in order. The second is judged by comparing each delivered token, its destination and every busy flag against a model in the bench.

// File: rtl/pkt_link_arb.sv
module pkt_link_arb #(
  parameter int NSRC  = 4,
  parameter int NDST  = 4,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC-1:0]               src_valid,
  input  logic [NSRC*9-1:0]             src_data,
  input  logic [NSRC*$clog2(NDST)-1:0]  src_dest,
  output logic [NSRC-1:0]               src_ready,
  output logic [NDST-1:0]               dst_valid,
  output logic [8:0]                    dst_data,
  input  logic [NDST-1:0]               dst_ready,
  output logic [NDST-1:0]               dst_busy,
  output logic                          link_busy,
  output logic [$clog2(NSRC)-1:0]       link_owner
);
  localparam int SW = $clog2(NSRC);
  localparam int DW = $clog2(NDST);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 9;
  localparam logic [8:0] END_TOK = 9'h101;

  logic [SW-1:0] owner, rr_last, pick, gnt;
  logic          locked, found;
  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          full, empty, push, pop;
  logic [8:0]    in_tok;
  logic [DW-1:0] in_dst, hd_dst;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= NSRC; k++) begin
      int j;
      j = int'(rr_last) + k;
      if (j >= NSRC) j = j - NSRC;
      if (!found && src_valid[j]) begin
        pick  = SW'(j);
        found = 1'b1;
      end
    end
  end

  assign gnt    = locked ? owner : pick;
  assign full   = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign empty  = (wp == rp);
  assign in_tok = src_data[gnt*9 +: 9];
  assign in_dst = src_dest[gnt*DW +: DW];

  always_comb begin
    src_ready = '0;
    if ((locked || found) && !full) src_ready[gnt] = 1'b1;
  end

  assign push = |(src_valid & src_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      owner   <= '0;
      rr_last <= SW'(NSRC - 1);
    end else if (push) begin
      rr_last <= gnt;
      owner   <= gnt;
      locked  <= (in_tok != END_TOK);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= {in_dst, in_tok};
  end

  assign hd_dst   = mem[rp[AW-1:0]][EW-1:9];
  assign dst_data = mem[rp[AW-1:0]][8:0];

  always_comb begin
    dst_valid = '0;
    if (!empty) dst_valid[hd_dst] = 1'b1;
  end

  assign pop = |(dst_valid & dst_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      dst_busy <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rp               <= rp + 1'b1;
        dst_busy[hd_dst] <= (dst_data != END_TOK);
      end
    end
  end

  assign link_busy  = locked;
  assign link_owner = owner;
endmodule

// File: rtl/pkt_link_arb_chk.sv
module pkt_link_arb_chk #(
  parameter int NSRC  = 4,
  parameter int NDST  = 4,
  parameter int DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NSRC-1:0]               src_valid,
  input logic [NSRC-1:0]               src_ready,
  input logic [NDST-1:0]               dst_valid,
  input logic [NDST-1:0]               dst_ready,
  input logic                          link_busy,
  input logic [$clog2(NSRC)-1:0]       link_owner
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic [CW-1:0] cnt;
  logic          pu, po;

  assign pu = |(src_valid & src_ready);
  assign po = |(dst_valid & dst_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else cnt <= cnt + CW'(pu) - CW'(po);
  end

  // R7
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dst_valid));

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_ready) <= 1);

  // R2
  owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_busy |-> ((src_ready & ~(NSRC'(1) << link_owner)) == '0));

  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> (src_ready == '0));

  // R5
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (dst_valid == '0));
endmodule

bind pkt_link_arb pkt_link_arb_chk #(.NSRC(NSRC), .NDST(NDST), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .link_busy(link_busy),
  .link_owner(link_owner));

// File: tb/sim_pkt_link_arb.sv
`timescale 1ns/1ps
module sim_pkt_link_arb;
  logic clk = 0, rst_n = 0;
  logic [3:0]  src_valid = '0;
  logic [35:0] src_data = '0;
  logic [7:0]  src_dest = '0;
  logic [3:0]  src_ready, dst_valid, dst_ready = '0, dst_busy;
  logic [8:0]  dst_data;
  logic        link_busy;
  logic [1:0]  link_owner;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pkt_link_arb u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int s, input int tok, input int d);
    src_data[s*9 +: 9] = 9'(tok);
    src_dest[s*2 +: 2] = 2'(d);
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    check("R1 link_busy", link_busy, 0);
    check("R1 src_ready", src_ready, 0);
    check("R1 dst_valid", dst_valid, 0);
    check("R1 dst_busy", dst_busy, 0);
  endtask

  task automatic t_lock;
    put(1, 9'h011, 2); put(3, 9'h033, 1);
    src_valid = 4'b1010; #1;
    check("R4 first pick", src_ready, 4'b0010);
    tick;
    check("R2 busy", link_busy, 1);
    check("R2 owner", link_owner, 1);
    put(1, 9'h105, 2); #1;
    check("R2 others held", src_ready, 4'b0010);
    tick;
    check("R3 ctrl keeps", link_busy, 1);
    put(1, 9'h101, 2); tick;
    check("R3 end frees", link_busy, 0);
    src_valid = 4'b1000; #1;
    check("R4 next", src_ready, 4'b1000);
    tick; put(3, 9'h101, 1); tick;
    src_valid = 4'b0000;
  endtask

  task automatic t_wrap;
    put(0, 9'h101, 3); put(1, 9'h101, 0);
    src_valid = 4'b1011; #1;
    check("R4 wrap", src_ready, 4'b0001);
    tick;
    check("R9 no lock", link_busy, 0);
    src_valid = 4'b0010; #1;
    check("R4 rotate", src_ready, 4'b0010);
    tick;
    src_valid = 4'b0000;
  endtask

  task automatic t_full;
    put(2, 9'h0AA, 2); src_valid = 4'b0100; tick;
    put(2, 9'h0BB, 2); #1;
    check("R6 full stall", src_ready, 0);
    check("R7 head dest", dst_valid, 4'b0100);
    check("R7 head data", dst_data, 9'h011);
    dst_ready = 4'b1011; tick;
    check("R10 head waits", dst_data, 9'h011);
    check("R10 still only d2", dst_valid, 4'b0100);
    check("R6 still stalled", src_ready, 0);
  endtask

  task automatic t_drain;
    int et[10] = '{9'h011, 9'h105, 9'h101, 9'h033, 9'h101, 9'h101, 9'h101, 9'h0AA, 9'h0BB, 9'h101};
    int ed[10] = '{2, 2, 2, 1, 1, 3, 0, 2, 2, 2};
    logic [3:0] mbusy = '0;
    int n = 0, sst = 0;
    bit stalled_seen = 0;
    dst_ready = 4'b1111;
    for (int c = 0; c < 30; c++) begin
      logic r;
      logic [3:0] v;
      logic [8:0] dd;
      #1;
      r = src_ready[2] & src_valid[2];
      v = dst_valid; dd = dst_data;
      if (v != 0) begin
        int d;
        d = (v == 4'b0001) ? 0 : (v == 4'b0010) ? 1 : (v == 4'b0100) ? 2 : 3;
        if (n < 10) begin
          check("R5 token", dd, et[n]);
          check("R5 dest", d, ed[n]);
          if (et[n] == 9'h101 && ed[n] == 3) check("R9 busy stays 0", dst_busy[3], 0);
        end
        mbusy[d] = (dd != 9'h101);
        n++;
      end
      tick;
      check("R8 busy flags", dst_busy, mbusy);
      if (r) begin
        sst++;
        if (sst == 1) put(2, 9'h101, 2);
        else src_valid = 4'b0000;
      end
      if (sst == 0 && n >= 1) stalled_seen = 1;
    end
    check("R5 count", n, 10);
    check("R6 resumed", sst, 2);
    check("R3 idle at end", link_busy, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk); #1 rst_n = 1;
        t_reset;
        t_lock;
        t_wrap;
        t_full;
        t_drain;
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule